// File: doc/BRIEF.md
# Event Counter Bank

The block holds eight independent 64-bit counters behind one register page. A single-cycle register strobe interface (separate write and read strobes, byte address, 64-bit data) reaches two registers per counter: a value register that holds the running count, and a configuration register whose low byte selects which event the counter watches.

Each counter adds one in every clock cycle in which its selected event strobe is high. There is no separate enable. A select code of zero leaves the counter idle, and any code from 1 to 36 makes it count. Software usually writes zero to the value register, then writes a select code to start counting. Later it writes code zero to freeze the count and reads the value back. Read data is registered and appears one cycle after the read strobe.

Top module: `evt_ctr_bank`

## Requirements
- R1: After a synchronous reset every count, every select code and the read data are zero.
- R2: Counter n's value register sits at byte offset 0x800 + 8*n and its configuration register at 0x900 + 8*n. The select code occupies bits 7:0 of the configuration register. Written bits above 7 are discarded and read back as zero.
- R3: With select code c in 1..36, the counter increases by one at every clock edge where evt_in[c-1] is high. The first edge that can count is the one after the configuration write.
- R4: Writing select code 0 stops the counter, and it then holds its value whatever the event inputs do.
- R5: A write to a value register loads the full 64-bit write data, so writing zero clears the counter. Counting continues from the loaded value.
- R6: When a value register write and a counted event fall on the same edge, the written data wins and no increment is applied.
- R7: A select code above 36 is stored and read back unchanged, but the counter does not move.
- R8: A count wraps from 2^64-1 to 0 with no flag.
- R9: A read of an unmapped or unaligned offset returns zero. A write there changes no register.
- R10: reg_rdata is loaded at the clock edge where reg_rd is high. It carries the register value from before that edge's update and holds until the next read.
- R11: Each counter follows only its own select code and its own writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe, one cycle per read |
| reg_addr | input | 12 | Byte offset in the register page |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| evt_in | input | 36 | Event strobes; bit k is event code k+1 |

## Verification
The bench targets the edge where a value write and an active event coincide. A design that let the increment win would read back one more than the written value. It also drives every event input high while a counter holds an out-of-range code or code zero. A design that indexed past the event vector or ignored the idle code would show a moving count. The bench further loads a counter just below the 64-bit limit and counts through the wrap. It issues reads at unaligned and unmapped offsets right after a nonzero read, so stale read data or a loose address decode shows up as a nonzero value. Finally, all eight counters run at once on different events, which catches crossed write enables or crossed event indexing.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_VAL  = 2'd1,
    ACC_CFG  = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/evc_decode.sv
module evc_decode
  import evc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_CTRS = 8,
  parameter int VAL_BASE = 'h800,
  parameter int CFG_BASE = 'h900,
  localparam int IDX_W   = $clog2(NUM_CTRS)
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);

  localparam int SPAN_W = 3 + IDX_W;
  localparam logic [ADDR_W-1:0] VAL_B = ADDR_W'(VAL_BASE);
  localparam logic [ADDR_W-1:0] CFG_B = ADDR_W'(CFG_BASE);

  always_comb begin
    kind = ACC_NONE;
    idx  = addr[SPAN_W-1:3];
    if (addr[2:0] == 3'b000) begin
      if (addr[ADDR_W-1:SPAN_W] == VAL_B[ADDR_W-1:SPAN_W])
        kind = ACC_VAL;
      else if (addr[ADDR_W-1:SPAN_W] == CFG_B[ADDR_W-1:SPAN_W])
        kind = ACC_CFG;
    end
  end

endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int CTR_W   = 64,
  parameter int SEL_W   = 8,
  parameter int NUM_EVT = 36
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_val,
  input  logic               ld_cfg,
  input  logic [CTR_W-1:0]   wdata,
  input  logic [NUM_EVT-1:0] evt,
  output logic [CTR_W-1:0]   cnt,
  output logic [SEL_W-1:0]   sel
);

  localparam int EXT_W = 1 << SEL_W;

  logic [EXT_W-1:0] evt_ext;
  logic             hit;

  // code 0 maps to a constant zero, codes past the event range to zero fill
  assign evt_ext = EXT_W'({evt, 1'b0});
  assign hit     = evt_ext[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (ld_cfg) begin
      sel <= wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld_val) begin
      cnt <= wdata;
    end else if (hit) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ld_val |=> cnt == $past(wdata));

  // R3 R8
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_val && sel != '0 && int'(sel) <= NUM_EVT && evt[sel - 1'b1])
      |=> cnt == $past(cnt) + 1'b1);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_val && sel == '0) |=> $stable(cnt));

  // R7
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_val && int'(sel) > NUM_EVT) |=> $stable(cnt));

endmodule

// File: rtl/evc_rdmux.sv
module evc_rdmux
  import evc_pkg::*;
#(
  parameter int NUM_CTRS = 8,
  parameter int CTR_W    = 64,
  parameter int SEL_W    = 8,
  localparam int IDX_W   = $clog2(NUM_CTRS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               rd,
  input  acc_kind_e                          kind,
  input  logic [IDX_W-1:0]                   idx,
  input  logic [NUM_CTRS-1:0][CTR_W-1:0]     counts,
  input  logic [NUM_CTRS-1:0][SEL_W-1:0]     sels,
  output logic [CTR_W-1:0]                   rdata
);

  logic [CTR_W-1:0] rd_next;

  always_comb begin
    case (kind)
      ACC_VAL: rd_next = counts[idx];
      ACC_CFG: rd_next = CTR_W'(sels[idx]);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rd_next;
    end
  end

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && kind == ACC_NONE) |=> rdata == '0);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));

  // R2
  cfg_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && kind == ACC_CFG) |=> rdata[CTR_W-1:SEL_W] == '0);

endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evc_pkg::*;
#(
  parameter int NUM_CTRS = 8,
  parameter int CTR_W    = 64,
  parameter int SEL_W    = 8,
  parameter int NUM_EVT  = 36,
  parameter int ADDR_W   = 12,
  parameter int VAL_BASE = 'h800,
  parameter int CFG_BASE = 'h900
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CTR_W-1:0]   reg_wdata,
  output logic [CTR_W-1:0]   reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in
);

  localparam int IDX_W = $clog2(NUM_CTRS);

  acc_kind_e                       dec_kind;
  logic [IDX_W-1:0]                dec_idx;
  logic [NUM_CTRS-1:0]             ld_val;
  logic [NUM_CTRS-1:0]             ld_cfg;
  logic [NUM_CTRS-1:0][CTR_W-1:0]  counts;
  logic [NUM_CTRS-1:0][SEL_W-1:0]  sels;

  evc_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_CTRS (NUM_CTRS),
    .VAL_BASE (VAL_BASE),
    .CFG_BASE (CFG_BASE)
  ) u_decode (
    .addr (reg_addr),
    .kind (dec_kind),
    .idx  (dec_idx)
  );

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
    assign ld_val[i] = reg_wr && dec_kind == ACC_VAL && dec_idx == IDX_W'(i);
    assign ld_cfg[i] = reg_wr && dec_kind == ACC_CFG && dec_idx == IDX_W'(i);

    evc_counter #(
      .CTR_W   (CTR_W),
      .SEL_W   (SEL_W),
      .NUM_EVT (NUM_EVT)
    ) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .ld_val (ld_val[i]),
      .ld_cfg (ld_cfg[i]),
      .wdata  (reg_wdata),
      .evt    (evt_in),
      .cnt    (counts[i]),
      .sel    (sels[i])
    );
  end

  evc_rdmux #(
    .NUM_CTRS (NUM_CTRS),
    .CTR_W    (CTR_W),
    .SEL_W    (SEL_W)
  ) u_rdmux (
    .clk    (clk),
    .rst    (rst),
    .rd     (reg_rd),
    .kind   (dec_kind),
    .idx    (dec_idx),
    .counts (counts),
    .sels   (sels),
    .rdata  (reg_rdata)
  );

  // R11
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_val, ld_cfg}));

  // R9
  no_stray_load_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && dec_kind == ACC_NONE) |=> ($stable(counts) || $past(evt_in) != '0));

endmodule

// File: tb/evt_ctr_bank_test.sv
module evt_ctr_bank_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [35:0] evt_in = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  evt_ctr_bank uut (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_in    (evt_in)
  );

  function automatic logic [11:0] vaddr(int n);
    return 12'h800 | 12'(n << 3);
  endfunction

  function automatic logic [11:0] caddr(int n);
    return 12'h900 | 12'(n << 3);
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%016h expected 0x%016h", tag, got, exp);
    end
  endtask

  // all tasks start and end right after a falling edge
  task automatic reg_write(logic [11:0] a, logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [11:0] a, output logic [63:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic run_events(logic [35:0] v, int n);
    evt_in = v;
    repeat (n) @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    check("R1 rdata after reset", reg_rdata, 64'd0);
    for (int n = 0; n < 8; n++) begin
      reg_read(vaddr(n), d); check("R1 value reset", d, 64'd0);
      reg_read(caddr(n), d); check("R1 select reset", d, 64'd0);
    end
  endtask

  task automatic t_count_basic();
    logic [63:0] d;
    reg_write(vaddr(2), 64'd0);
    reg_write(caddr(2), 64'h05);
    run_events(36'h10, 10);   // event code 5
    run_events(36'h08, 4);    // code 4: not selected
    reg_read(vaddr(2), d); check("R3 count of code 5", d, 64'd10);
  endtask

  task automatic t_stop_resume();
    logic [63:0] d;
    reg_write(caddr(2), 64'h00);
    run_events(36'h10, 6);
    reg_read(vaddr(2), d); check("R4 idle holds", d, 64'd10);
    reg_write(caddr(2), 64'h05);
    run_events(36'h10, 3);
    reg_read(vaddr(2), d); check("R3 resume accumulates", d, 64'd13);
  endtask

  task automatic t_clear_preset();
    logic [63:0] d;
    reg_write(vaddr(2), 64'd0);
    reg_read(vaddr(2), d); check("R5 clear by write", d, 64'd0);
    reg_write(vaddr(2), 64'd1000);
    run_events(36'h10, 2);
    reg_read(vaddr(2), d); check("R5 count from preset", d, 64'd1002);
  endtask

  task automatic t_priority();
    logic [63:0] d;
    reg_write(caddr(1), 64'h01);
    evt_in = 36'h1;
    @(negedge clk);
    reg_write(vaddr(1), 64'd100);
    // read edge sees the value loaded at the write edge, before its own increment
    reg_read(vaddr(1), d); check("R6 write beats increment", d, 64'd100);
    evt_in = '0;
    reg_read(vaddr(1), d); check("R10 count continues after load", d, 64'd101);
  endtask

  task automatic t_bad_code();
    logic [63:0] d;
    reg_write(caddr(4), 64'h30);
    reg_read(caddr(4), d); check("R7 out-of-range code readback", d, 64'h30);
    run_events('1, 5);
    reg_read(vaddr(4), d); check("R7 out-of-range code counts nothing", d, 64'd0);
  endtask

  task automatic t_cfg_width();
    logic [63:0] d;
    reg_write(caddr(5), 64'hFFFF_FFFF_FFFF_FF24);
    reg_read(caddr(5), d); check("R2 select byte only", d, 64'h24);
    run_events(36'h8_0000_0000, 4);  // code 0x24
    reg_read(vaddr(5), d); check("R3 highest code counts", d, 64'd4);
  endtask

  task automatic t_wrap();
    logic [63:0] d;
    reg_write(vaddr(6), 64'hFFFF_FFFF_FFFF_FFFE);
    reg_write(caddr(6), 64'h07);
    run_events(36'h40, 3);
    reg_read(vaddr(6), d); check("R8 wrap past all ones", d, 64'd1);
  endtask

  task automatic t_unmapped();
    logic [63:0] d;
    logic [11:0] bad [5] = '{12'h804, 12'h840, 12'h000, 12'h940, 12'hA00};
    for (int k = 0; k < 5; k++) begin
      reg_read(vaddr(5), d);
      reg_read(bad[k], d); check("R9 unmapped read zero", d, 64'd0);
    end
    reg_write(12'h804, 64'd55);
    reg_write(12'h901, 64'h09);
    reg_write(12'h940, 64'h09);
    reg_read(vaddr(0), d); check("R9 stray write leaves value", d, 64'd0);
    reg_read(caddr(0), d); check("R9 stray write leaves select", d, 64'd0);
  endtask

  task automatic t_read_hold();
    logic [63:0] d;
    reg_read(vaddr(5), d);
    reg_write(caddr(0), 64'h01);
    run_events(36'h1, 3);
    check("R10 rdata holds without read", reg_rdata, 64'd4);
  endtask

  task automatic t_independent();
    logic [63:0] d;
    for (int n = 0; n < 8; n++) reg_write(caddr(n), 64'(n + 1));
    for (int n = 0; n < 8; n++) reg_write(vaddr(n), 64'd0);
    run_events(36'hFF, 3);
    run_events(36'h0F, 2);
    for (int n = 0; n < 8; n++) begin
      reg_read(vaddr(n), d);
      check("R11 independent counters", d, (n < 4) ? 64'd5 : 64'd3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count_basic();
    t_stop_resume();
    t_clear_preset();
    t_priority();
    t_bad_code();
    t_cfg_width();
    t_wrap();
    t_unmapped();
    t_read_hold();
    t_independent();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule